// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block is a line buffer with two fully separate ports. The write port runs on its own clock and keeps its own address counter. Every enabled write edge stores one word and moves that counter forward. The read port runs on a second clock that has no fixed relation to the first. It keeps a second counter, and every enabled read edge presents one stored word and moves that counter forward.

The block has no full or empty flag and never compares the two counters. The delay between a word going in and coming out depends only on when each counter was last restarted by its own active-low reset pulse. A video or scanner pipeline uses this to get a delay of any length up to one full line. The read output is registered. When reading is disabled the output is turned off: an output-enable signal drops, and the data pins read as zero so that a chip-level pad or bus can float them.

By default the block holds 8192 words of 10 bits. Both ports must be reset once after power-up before the stored contents mean anything.

Top module: `line_delay_mem`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_en_n` low and `wr_rst_n` high, `wr_data` is stored at the current write address and the write address advances by one.
- R2: On a rising `wr_clk` edge with `wr_en_n` high, nothing is stored. The write address keeps its value, unless R3 applies on the same edge.
- R3: On a rising `wr_clk` edge with `wr_rst_n` low, the write address returns to 0 and reset wins over enable. With `wr_en_n` high the address is then 0. With `wr_en_n` low the word is stored at address 0 and the address becomes 1.
- R4: On a rising `rd_clk` edge with `rd_en_n` low, the word at the current read address is registered onto `rd_data`, `rd_oe` goes high, and the read address advances by one.
- R5: On a rising `rd_clk` edge with `rd_en_n` high, the read address keeps its value, `rd_oe` goes low, and `rd_data` reads as all zeros.
- R6: On a rising `rd_clk` edge with `rd_rst_n` low, the read address returns to 0 and reset wins over enable. With `rd_en_n` low, address 0 is read and the address becomes 1.
- R7: Both address counters wrap from DEPTH-1 back to 0, so a write past the last address overwrites address 0.
- R8: The two ports need no handshake. Data written under `wr_clk` is read back unchanged under an unrelated `rd_clk`, and the data path adds no latency beyond the one-edge read register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Write address restart, active low, sampled on `wr_clk` |
| wr_data | input | WIDTH | Word to store |
| rd_clk | input | 1 | Read port clock, asynchronous to `wr_clk` |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Read address restart, active low, sampled on `rd_clk` |
| rd_data | output | WIDTH | Registered read word, zero while the output is off |
| rd_oe | output | 1 | High while `rd_data` should be driven off-chip |

## Verification
The bench builds the block with DEPTH 16 and WIDTH 10. WIDTH keeps its default, so every data pattern is one the default configuration carries. The small depth lets a run of 18 writes and 18 reads cross both wrap points within a few dozen cycles, so overwriting address 0 and the read counter wrapping are both observed. Running the write clock at 8 ns and the read clock at 11 ns means the two ports never share an edge pattern.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

  localparam int unsigned DLM_DEPTH_DEF = 8192;
  localparam int unsigned DLM_WIDTH_DEF = 10;

  // what one port does on a clock edge: {restart, step}
  typedef enum logic [1:0] {
    PA_HOLD         = 2'b00,
    PA_STEP         = 2'b01,
    PA_RESTART      = 2'b10,
    PA_RESTART_STEP = 2'b11
  } port_act_t;

endpackage

// File: rtl/dlm_addr_ctr.sv
module dlm_addr_ctr
  import dlm_pkg::*;
#(
  parameter int unsigned DEPTH = DLM_DEPTH_DEF,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  output logic [AW-1:0] addr_o,
  output logic          acc_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  port_act_t     act;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic [AW-1:0] base;
  logic [AW-1:0] step;
  logic          upd;

  // next-state logic
  always_comb begin
    act = port_act_t'({~rst_n, ~en_n});
    base = ptr_q;
    upd = 1'b0;
    case (act)
      PA_HOLD:         begin base = ptr_q; upd = 1'b0; end
      PA_STEP:         begin base = ptr_q; upd = 1'b1; end
      PA_RESTART:      begin base = '0;    upd = 1'b1; end
      PA_RESTART_STEP: begin base = '0;    upd = 1'b1; end
      default:         begin base = ptr_q; upd = 1'b0; end
    endcase
    step  = (base == LAST) ? '0 : base + AW'(1);
    ptr_d = en_n ? base : step;
  end

  // register with explicit clock enable
  always_ff @(posedge clk) begin
    if (upd) begin
      ptr_q <= ptr_d;
    end
  end

  assign addr_o = base;
  assign acc_o  = ~en_n;

  // R3
  rst_idle_zero_chk: assert property (@(posedge clk)
    (!rst_n && en_n) |=> (ptr_q == '0));

  // R3
  rst_step_one_chk: assert property (@(posedge clk)
    (!rst_n && !en_n) |=> (ptr_q == ((LAST == '0) ? '0 : AW'(1))));

  // R2
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> $stable(ptr_q));

  // R7
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + AW'(1))));

endmodule

// File: rtl/dlm_ram.sv
module dlm_ram #(
  parameter int unsigned DEPTH = 8192,
  parameter int unsigned WIDTH = 10,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             wr_we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_re,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_q,
  output logic             rd_oe
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] q_q;
  logic             oe_q;

  always_ff @(posedge wr_clk) begin
    if (wr_we) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge rd_clk) begin
    oe_q <= rd_re;
    if (rd_re) begin
      q_q <= mem[rd_addr];
    end
  end

  assign rd_q  = q_q;
  assign rd_oe = oe_q;

  // R1
  store_word_chk: assert property (@(posedge wr_clk)
    wr_we |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem
  import dlm_pkg::*;
#(
  parameter int unsigned DEPTH = DLM_DEPTH_DEF,
  parameter int unsigned WIDTH = DLM_WIDTH_DEF
) (
  input  logic             wr_clk,
  input  logic             wr_en_n,
  input  logic             wr_rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_en_n,
  input  logic             rd_rst_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    wa;
  logic [AW-1:0]    ra;
  logic             we;
  logic             re;
  logic [WIDTH-1:0] q;
  logic             oe;

  dlm_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ctr (
    .clk    (wr_clk),
    .rst_n  (wr_rst_n),
    .en_n   (wr_en_n),
    .addr_o (wa),
    .acc_o  (we)
  );

  dlm_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ctr (
    .clk    (rd_clk),
    .rst_n  (rd_rst_n),
    .en_n   (rd_en_n),
    .addr_o (ra),
    .acc_o  (re)
  );

  dlm_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram (
    .wr_clk  (wr_clk),
    .wr_we   (we),
    .wr_addr (wa),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_re   (re),
    .rd_addr (ra),
    .rd_q    (q),
    .rd_oe   (oe)
  );

  assign rd_data = oe ? q : '0;
  assign rd_oe   = oe;

  // R4
  oe_on_chk: assert property (@(posedge rd_clk)
    (!rd_en_n) |=> rd_oe);

  // R5
  oe_off_chk: assert property (@(posedge rd_clk)
    rd_en_n |=> (!rd_oe && (rd_data == '0)));

endmodule

// File: tb/tb_line_delay_mem.sv
`timescale 1ns/1ps
module tb_line_delay_mem;

  localparam int DEPTH = 16;
  localparam int WIDTH = 10;
  localparam int NW    = 10;

  // stimulus table: [11] wr_en_n, [10] wr_rst_n, [9:0] data
  localparam logic [11:0] WTAB [NW] = '{
    {1'b0, 1'b0, 10'h155},
    {1'b0, 1'b1, 10'h0A1},
    {1'b0, 1'b1, 10'h0B2},
    {1'b0, 1'b1, 10'h0C3},
    {1'b1, 1'b1, 10'h3FF},
    {1'b0, 1'b1, 10'h0D4},
    {1'b1, 1'b0, 10'h3FE},
    {1'b0, 1'b1, 10'h2AA},
    {1'b0, 1'b1, 10'h111},
    {1'b0, 1'b1, 10'h222}
  };

  logic             wr_clk = 1'b0;
  logic             rd_clk = 1'b0;
  logic             wr_en_n, wr_rst_n, rd_en_n, rd_rst_n;
  logic [WIDTH-1:0] wr_data;
  logic [WIDTH-1:0] rd_data;
  logic             rd_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [WIDTH-1:0] model [DEPTH];
  int wa_m = 0;
  int ra_m = 0;

  always #4   wr_clk = ~wr_clk;   // 125 MHz
  always #5.5 rd_clk = ~rd_clk;

  line_delay_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .wr_clk   (wr_clk),
    .wr_en_n  (wr_en_n),
    .wr_rst_n (wr_rst_n),
    .wr_data  (wr_data),
    .rd_clk   (rd_clk),
    .rd_en_n  (rd_en_n),
    .rd_rst_n (rd_rst_n),
    .rd_data  (rd_data),
    .rd_oe    (rd_oe)
  );

  task automatic wr_cycle(input logic en_n, input logic rst_n, input logic [WIDTH-1:0] d);
    int a;
    wr_en_n  = en_n;
    wr_rst_n = rst_n;
    wr_data  = d;
    @(posedge wr_clk);
    a = rst_n ? wa_m : 0;
    if (!en_n) begin
      model[a] = d;
      wa_m = (a == DEPTH - 1) ? 0 : a + 1;
    end else begin
      wa_m = a;
    end
    @(negedge wr_clk);
    wr_en_n  = 1'b1;
    wr_rst_n = 1'b1;
  endtask

  task automatic rd_cycle(input logic en_n, input logic rst_n, input string tag);
    int a;
    logic [WIDTH-1:0] exp_d;
    logic             exp_oe;
    rd_en_n  = en_n;
    rd_rst_n = rst_n;
    @(posedge rd_clk);
    a = rst_n ? ra_m : 0;
    if (!en_n) begin
      exp_d  = model[a];
      exp_oe = 1'b1;
      ra_m   = (a == DEPTH - 1) ? 0 : a + 1;
    end else begin
      exp_d  = '0;
      exp_oe = 1'b0;
      ra_m   = a;
    end
    @(negedge rd_clk);
    rd_en_n  = 1'b1;
    rd_rst_n = 1'b1;
    checks++;
    if (rd_data !== exp_d || rd_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: rd_data=%h rd_oe=%b expected rd_data=%h rd_oe=%b",
               tag, rd_data, rd_oe, exp_d, exp_oe);
    end
  endtask

  initial begin
    wr_en_n = 1'b1; wr_rst_n = 1'b1; wr_data = '0;
    rd_en_n = 1'b1; rd_rst_n = 1'b1;
    repeat (3) @(negedge wr_clk);
    @(negedge rd_clk);

    // reset state of the read side: restart without enable, output off (R6, R5)
    rd_cycle(1'b1, 1'b0, "R6 reset state");

    // table walk on the write side (R1, R2, R3)
    @(negedge wr_clk);
    for (int i = 0; i < NW; i++) begin
      wr_cycle(WTAB[i][11], WTAB[i][10], WTAB[i][9:0]);
    end

    // read back: address 0 holds the post-restart word, address 4 the word
    // written after the disabled cycle (R2 ignored data)
    @(negedge rd_clk);
    rd_cycle(1'b0, 1'b0, "R6 restart read addr0");
    rd_cycle(1'b0, 1'b1, "R4 read addr1");
    rd_cycle(1'b1, 1'b1, "R5 read disabled");
    rd_cycle(1'b0, 1'b1, "R4 resume addr2");
    rd_cycle(1'b0, 1'b1, "R3 addr3 kept");
    rd_cycle(1'b0, 1'b1, "R2 addr4 not disabled data");
    rd_cycle(1'b1, 1'b0, "R6 restart idle");
    rd_cycle(1'b0, 1'b1, "R3 addr0 overwritten after restart");

    // wrap on both ports (R7, R8)
    @(negedge wr_clk);
    wr_cycle(1'b0, 1'b0, 10'h200);
    for (int i = 1; i < DEPTH + 2; i++) begin
      wr_cycle(1'b0, 1'b1, WIDTH'(10'h200 + i));
    end
    @(negedge rd_clk);
    rd_cycle(1'b0, 1'b0, "R7 wrapped addr0");
    for (int i = 1; i < DEPTH + 2; i++) begin
      rd_cycle(1'b0, 1'b1, "R7 R8 wrap sweep");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule